// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps a small table of message-signalled interrupt vectors together with the pending bit array that goes with it. Software reaches both through a register access port that takes 32-bit and 64-bit reads and writes. A separate message control port holds the function-wide enable and function mask bits. It also reports a read-only field that gives the table size minus one.

When a vector is triggered, the block offers a message write on an output valid/ready handshake. The write carries the vector's 64-bit address and 32-bit data. A vector that cannot be delivered is recorded as pending instead. That happens when the function is disabled, the function mask is set, or the vector's own mask bit is set. Clearing a mask replays the recorded messages and clears their pending bits. Clearing the function mask replays every unmasked pending vector. Clearing a single vector's mask replays that vector alone.

A two-state sender works through the eligible vectors. In `SND_IDLE` it picks the lowest eligible vector, latches its address and data, and moves to `SND_OFFER`. In `SND_OFFER` it holds the message until `msg_ready`. On the accepting edge it takes one of two transitions. `OFFER->OFFER` loads the next eligible vector when there is one. `OFFER->IDLE` is taken when none is left.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Entry v of the table starts at byte offset v*16 (`acc_pba`=0). A 32-bit access reaches address low at +0x0, address high at +0x4, data at +0x8 and vector control at +0xC, with the value in `acc_wdata[31:0]`/`acc_rdata[31:0]` and the upper read half zero.
- R2: A 64-bit access at entry offset +0x0 covers {address high, address low}, and one at +0x8 covers {vector control, data}, with the higher register in bits 63:32.
- R3: Illegal accesses read as zero and change nothing. An access is illegal when the offset is not 4-aligned, when a 64-bit access sits at +0x4 or +0xC, or when the entry or word is beyond the table. All writes to the pending array (`acc_pba`=1) are ignored.
- R4: On `ctl_rdata`, bit 15 is the enable and bit 14 the function mask. These are the only bits a `ctl_we` write changes. Bits 10:0 read as NUM_VEC-1 and all other bits read zero.
- R5: A trigger on a vector while the function is enabled, the function mask is 0 and vector control bit 0 is 0 produces one message of {address high, address low} and data, and leaves its pending bit clear.
- R6: A trigger while the function is disabled, function-masked or vector-masked produces no message. It sets pending bit v, which is bit v%64 of 64-bit word v/64 in the pending array (`acc_pba`=1, word offset 8*(v/64)). A 32-bit read at word offset +0x4 returns the upper half.
- R7: A vector control write that moves bit 0 from 1 to 0 while the function mask is 0 and the pending bit is set sends that vector's message and clears its pending bit. Other pending vectors stay pending.
- R8: A function mask change from 1 to 0 replays every pending vector whose own mask is 0, in ascending vector order, on back-to-back handshakes. Each replay clears its pending bit, and vector-masked pending bits stay set.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R10: After reset all table registers, the pending array, the enable and the function mask are zero and `msg_valid` is low.
- R11: Setting the enable bit alone does not replay pending vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 64-bit, 0 = 32-bit access |
| acc_pba | input | 1 | 1 = pending array, 0 = vector table |
| acc_off | input | $clog2(NUM_VEC)+4 | Byte offset within the selected region |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, valid in the access cycle |
| ctl_we | input | 1 | Message control write strobe |
| ctl_wdata | input | 16 | Message control write value |
| ctl_rdata | output | 16 | Message control read value |
| fire_valid | input | 1 | Vector trigger strobe |
| fire_vec | input | $clog2(NUM_VEC) | Triggered vector number |
| msg_valid | output | 1 | Message write offered |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench goes after the unmask corner cases, starting with a function mask release while several vectors are pending and one of them is still vector-masked. A design that got this wrong would skip or reorder a replay, or add a bubble between replays. It would also send the masked vector, or clear its pending bit. Enabling the function with vectors pending must stay silent. A design that treated enable like an unmask would emit messages there. Illegal offsets and sizes, and writes to the pending array, are aimed at decoders that corrupt neighbouring registers or return stale data. A message stalled on `msg_ready` is watched for an address or data that changes under the stall.

// File: rtl/msix_pkg.sv
package msix_pkg;
    typedef enum logic [0:0] {
        SND_IDLE  = 1'b0,
        SND_OFFER = 1'b1
    } snd_state_e;

    localparam int PBA_WORD_BITS = 64;
    localparam int CTL_EN_BIT    = 15;
    localparam int CTL_FMASK_BIT = 14;
    localparam int CTL_SIZE_W    = 11;
endpackage

// File: rtl/msix_table.sv
module msix_table #(
    parameter int NUM_VEC = 8,
    localparam int VW    = $clog2(NUM_VEC),
    localparam int OFF_W = VW + 4,
    localparam int PW    = (NUM_VEC + 63) / 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_wide,
    input  logic               acc_pba,
    input  logic [OFF_W-1:0]   acc_off,
    input  logic [63:0]        acc_wdata,
    output logic [63:0]        acc_rdata,
    input  logic [NUM_VEC-1:0] pend,
    input  logic [VW-1:0]      lk_idx,
    output logic [63:0]        lk_addr,
    output logic [31:0]        lk_data,
    output logic [NUM_VEC-1:0] vmask,
    output logic [NUM_VEC-1:0] vunmask
);
    logic [31:0] lo_q  [NUM_VEC];
    logic [31:0] hi_q  [NUM_VEC];
    logic [31:0] dat_q [NUM_VEC];
    logic [31:0] ctl_q [NUM_VEC];

    logic [VW-1:0]      ent;
    logic [1:0]         fld;
    logic [OFF_W-4:0]   word;
    logic               tbl_ok, pba_ok, wr_ok, ctl_hit, new_mbit;
    logic [PW*64-1:0]   pba_flat;
    logic [63:0]        pw;

    assign ent  = acc_off[OFF_W-1:4];
    assign fld  = acc_off[3:2];
    assign word = acc_off[OFF_W-1:3];

    always_comb begin
        tbl_ok = !acc_pba && (acc_off[1:0] == 2'b00) && (!acc_wide || !acc_off[2])
                 && (int'(ent) < NUM_VEC);
        pba_ok = acc_pba && (acc_off[1:0] == 2'b00) && (!acc_wide || !acc_off[2])
                 && (int'(word) < PW);
        wr_ok  = acc_valid && acc_write && tbl_ok;
        ctl_hit  = wr_ok && (acc_wide ? fld[1] : (fld == 2'd3));
        new_mbit = acc_wide ? acc_wdata[32] : acc_wdata[0];
    end

    always_ff @(posedge clk) begin
        for (int v = 0; v < NUM_VEC; v++) begin
            if (!rst_n) begin
                lo_q[v]  <= '0;
                hi_q[v]  <= '0;
                dat_q[v] <= '0;
                ctl_q[v] <= '0;
            end else if (wr_ok && int'(ent) == v) begin
                if (acc_wide) begin
                    if (fld[1]) begin
                        dat_q[v] <= acc_wdata[31:0];
                        ctl_q[v] <= acc_wdata[63:32];
                    end else begin
                        lo_q[v] <= acc_wdata[31:0];
                        hi_q[v] <= acc_wdata[63:32];
                    end
                end else begin
                    unique case (fld)
                        2'd0: lo_q[v]  <= acc_wdata[31:0];
                        2'd1: hi_q[v]  <= acc_wdata[31:0];
                        2'd2: dat_q[v] <= acc_wdata[31:0];
                        2'd3: ctl_q[v] <= acc_wdata[31:0];
                    endcase
                end
            end
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_mask
        assign vmask[v]   = ctl_q[v][0];
        assign vunmask[v] = ctl_hit && (int'(ent) == v) && ctl_q[v][0] && !new_mbit;
    end

    assign lk_addr = {hi_q[lk_idx], lo_q[lk_idx]};
    assign lk_data = dat_q[lk_idx];

    always_comb begin
        pba_flat = '0;
        pba_flat[NUM_VEC-1:0] = pend;
        pw = '0;
        acc_rdata = '0;
        if (acc_valid && !acc_write) begin
            if (tbl_ok) begin
                if (acc_wide) begin
                    acc_rdata = fld[1] ? {ctl_q[ent], dat_q[ent]} : {hi_q[ent], lo_q[ent]};
                end else begin
                    unique case (fld)
                        2'd0: acc_rdata = {32'b0, lo_q[ent]};
                        2'd1: acc_rdata = {32'b0, hi_q[ent]};
                        2'd2: acc_rdata = {32'b0, dat_q[ent]};
                        2'd3: acc_rdata = {32'b0, ctl_q[ent]};
                    endcase
                end
            end else if (pba_ok) begin
                pw = pba_flat[int'(word)*64 +: 64];
                acc_rdata = acc_wide ? pw : {32'b0, (acc_off[2] ? pw[63:32] : pw[31:0])};
            end
        end
    end
endmodule

// File: rtl/msix_pend.sv
module msix_pend #(
    parameter int NUM_VEC = 8,
    localparam int VW = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_valid,
    input  logic [VW-1:0]      fire_vec,
    input  logic               fire_ok,
    input  logic [NUM_VEC-1:0] arm_set,
    input  logic               clr_valid,
    input  logic [VW-1:0]      clr_vec,
    output logic [NUM_VEC-1:0] pend,
    output logic [NUM_VEC-1:0] arm
);
    logic [NUM_VEC-1:0] pend_d, arm_d;

    always_comb begin
        pend_d = pend;
        arm_d  = arm;
        if (clr_valid) begin
            pend_d[clr_vec] = 1'b0;
            arm_d[clr_vec]  = 1'b0;
        end
        if (fire_valid) begin
            pend_d[fire_vec] = 1'b1;
            if (fire_ok) arm_d[fire_vec] = 1'b1;
        end
        arm_d = (arm_d | arm_set) & pend_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            arm  <= '0;
        end else begin
            pend <= pend_d;
            arm  <= arm_d;
        end
    end

    // R6
    undeliverable_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid && !fire_ok |=> pend[$past(fire_vec)]);
    // R3
    pba_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_valid && !clr_valid |=> $stable(pend));
    // R5
    send_only_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> pend[clr_vec]);
endmodule

// File: rtl/msix_sender.sv
module msix_sender
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VW = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] elig,
    input  logic [63:0]        lk_addr,
    input  logic [31:0]        lk_data,
    output logic [VW-1:0]      lk_idx,
    input  logic               msg_ready,
    output logic               msg_valid,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic               clr_valid,
    output logic [VW-1:0]      clr_vec
);
    snd_state_e         state, state_d;
    logic [VW-1:0]      cur;
    logic [NUM_VEC-1:0] cand;
    logic               any, load;

    always_comb begin
        cand = elig;
        if (state == SND_OFFER) cand[cur] = 1'b0;
        any    = |cand;
        lk_idx = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (cand[v]) lk_idx = VW'(v);
        end
        state_d = state;
        load    = 1'b0;
        unique case (state)
            SND_IDLE: begin
                if (any) begin
                    state_d = SND_OFFER;
                    load    = 1'b1;
                end
            end
            SND_OFFER: begin
                if (msg_ready) begin
                    state_d = any ? SND_OFFER : SND_IDLE;
                    load    = any;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SND_IDLE;
            cur      <= '0;
            msg_addr <= '0;
            msg_data <= '0;
        end else begin
            state <= state_d;
            if (load) begin
                cur      <= lk_idx;
                msg_addr <= lk_addr;
                msg_data <= lk_data;
            end
        end
    end

    always_comb begin
        msg_valid = (state == SND_OFFER);
        clr_valid = (state == SND_OFFER) && msg_ready;
        clr_vec   = cur;
    end

    // R9
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VW    = $clog2(NUM_VEC),
    localparam int OFF_W = VW + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_wide,
    input  logic             acc_pba,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [63:0]      acc_wdata,
    output logic [63:0]      acc_rdata,
    input  logic             ctl_we,
    input  logic [15:0]      ctl_wdata,
    output logic [15:0]      ctl_rdata,
    input  logic             fire_valid,
    input  logic [VW-1:0]    fire_vec,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [63:0]      msg_addr,
    output logic [31:0]      msg_data
);
    logic               en_q, fm_q, fm_fall, fire_ok, clr_valid;
    logic [VW-1:0]      clr_vec, lk_idx;
    logic [NUM_VEC-1:0] pend, arm, vmask, vunmask, arm_set, elig;
    logic [63:0]        lk_addr;
    logic [31:0]        lk_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            fm_q <= 1'b0;
        end else if (ctl_we) begin
            en_q <= ctl_wdata[CTL_EN_BIT];
            fm_q <= ctl_wdata[CTL_FMASK_BIT];
        end
    end

    always_comb begin
        ctl_rdata = '0;
        ctl_rdata[CTL_EN_BIT]       = en_q;
        ctl_rdata[CTL_FMASK_BIT]    = fm_q;
        ctl_rdata[CTL_SIZE_W-1:0]   = CTL_SIZE_W'(NUM_VEC - 1);
        fm_fall = ctl_we && fm_q && !ctl_wdata[CTL_FMASK_BIT];
        arm_set = vunmask | {NUM_VEC{fm_fall}};
        fire_ok = en_q && !fm_q && !vmask[fire_vec];
        elig    = pend & arm & ~vmask & {NUM_VEC{!fm_q}};
    end

    msix_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_wide(acc_wide),
        .acc_pba(acc_pba), .acc_off(acc_off), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .pend(pend), .lk_idx(lk_idx),
        .lk_addr(lk_addr), .lk_data(lk_data), .vmask(vmask), .vunmask(vunmask)
    );

    msix_pend #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .fire_valid(fire_valid), .fire_vec(fire_vec), .fire_ok(fire_ok),
        .arm_set(arm_set), .clr_valid(clr_valid), .clr_vec(clr_vec),
        .pend(pend), .arm(arm)
    );

    msix_sender #(.NUM_VEC(NUM_VEC)) u_sender (
        .clk(clk), .rst_n(rst_n), .elig(elig),
        .lk_addr(lk_addr), .lk_data(lk_data), .lk_idx(lk_idx),
        .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data),
        .clr_valid(clr_valid), .clr_vec(clr_vec)
    );

    // R4
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_rdata[15:14] == $past(ctl_wdata[15:14]));
endmodule

// File: tb/msix_vec_ctrl_tb.sv
module msix_vec_ctrl_tb;
    localparam int NV = 8;
    localparam int VW = $clog2(NV);
    localparam int OW = VW + 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 0, acc_write = 0, acc_wide = 0, acc_pba = 0;
    logic [OW-1:0] acc_off = '0;
    logic [63:0] acc_wdata = '0, acc_rdata;
    logic ctl_we = 0;
    logic [15:0] ctl_wdata = '0, ctl_rdata;
    logic fire_valid = 0;
    logic [VW-1:0] fire_vec = '0;
    logic msg_valid, msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    int checks = 0, fails = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    msix_vec_ctrl #(.NUM_VEC(NV)) u_dut (.*);

    localparam int NT = 8;
    localparam logic        TV_WWIDE [NT] = '{0, 0, 1, 1, 0, 0, 1, 0};
    localparam logic [6:0]  TV_WOFF  [NT] = '{7'h00, 7'h14, 7'h20, 7'h38, 7'h3C, 7'h02, 7'h04, 7'h16};
    localparam logic [63:0] TV_WD    [NT] = '{64'hAAAA0000, 64'h1111, 64'h12345678_9ABCDEF0,
                                              64'h00000001_CAFEF00D, 64'h0, 64'hFFFFFFFF,
                                              64'hFFFFFFFF_FFFFFFFF, 64'h77};
    localparam logic        TV_RWIDE [NT] = '{0, 0, 0, 1, 0, 0, 0, 0};
    localparam logic [6:0]  TV_ROFF  [NT] = '{7'h00, 7'h14, 7'h24, 7'h38, 7'h38, 7'h00, 7'h04, 7'h16};
    localparam logic [63:0] TV_EXP   [NT] = '{64'hAAAA0000, 64'h1111, 64'h12345678,
                                              64'h00000001_CAFEF00D, 64'hCAFEF00D, 64'hAAAA0000,
                                              64'h0, 64'h0};

    function automatic logic [31:0] e_lo(int v);  return 32'hF000_0000 + 32'(v * 16); endfunction
    function automatic logic [31:0] e_hi(int v);  return 32'h0000_00A0 + 32'(v);      endfunction
    function automatic logic [31:0] e_dat(int v); return 32'h0000_D000 + 32'(v);      endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic wide, logic pba, logic [OW-1:0] off, logic [63:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_wide = wide; acc_pba = pba; acc_off = off; acc_wdata = d;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd(logic wide, logic pba, logic [OW-1:0] off, output logic [63:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_wide = wide; acc_pba = pba; acc_off = off;
        #1 d = acc_rdata;
        acc_valid = 0;
    endtask

    task automatic ctl(logic [15:0] d);
        @(negedge clk);
        ctl_we = 1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic fire(int v);
        @(negedge clk);
        fire_valid = 1; fire_vec = VW'(v);
        @(negedge clk);
        fire_valid = 0;
    endtask

    task automatic expect_msg(string tag, int v, output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!msg_valid && waited < 20);
        chk({tag, " valid"}, 64'(msg_valid), 64'd1);
        chk({tag, " addr"}, msg_addr, {e_hi(v), e_lo(v)});
        chk({tag, " data"}, 64'(msg_data), 64'(e_dat(v)));
    endtask

    task automatic no_msg(string tag, int n);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        chk(tag, 64'(seen), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(0, 0, 7'h00, r);  chk("R10 table lo", r, 64'h0);
        rd(1, 0, 7'h78, r);  chk("R10 table entry7", r, 64'h0);
        rd(1, 1, 7'h00, r);  chk("R10 pba", r, 64'h0);
        chk("R10 ctl", 64'(ctl_rdata), 64'h0007);
        chk("R10 msg_valid", 64'(msg_valid), 64'h0);

        // R1 R2 R3 vector walk
        for (int i = 0; i < NT; i++) begin
            wr(TV_WWIDE[i], 0, TV_WOFF[i], TV_WD[i]);
            rd(TV_RWIDE[i], 0, TV_ROFF[i], r);
            chk($sformatf("R1/R2/R3 row %0d", i), r, TV_EXP[i]);
        end
        rd(1, 0, 7'h0C, r);  chk("R3 wide at +0xC reads zero", r, 64'h0);

        // R4 message control
        ctl(16'hFFFF);  chk("R4 ctl all ones", 64'(ctl_rdata), 64'hC007);
        ctl(16'h8000);  chk("R4 enable only", 64'(ctl_rdata), 64'h8007);

        for (int v = 0; v < NV; v++) begin
            wr(1, 0, OW'(v * 16), {e_hi(v), e_lo(v)});
            wr(1, 0, OW'(v * 16 + 8), {32'h0, e_dat(v)});
        end

        // R5 direct delivery
        fire(5);
        expect_msg("R5 vec5", 5, w);
        @(negedge clk);
        rd(1, 1, 7'h00, r);  chk("R5 pba clear", r, 64'h0);

        // R9 stall holds the offer
        msg_ready = 1'b0;
        fire(0);
        expect_msg("R9 first", 0, w);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 held valid", 64'(msg_valid), 64'd1);
            chk("R9 held addr", msg_addr, {e_hi(0), e_lo(0)});
        end
        msg_ready = 1'b1;
        @(negedge clk);
        chk("R9 consumed", 64'(msg_valid), 64'd0);

        // R6 undeliverable triggers pend
        wr(0, 0, 7'h6C, 64'h1);
        fire(6);
        no_msg("R6 masked vector silent", 8);
        ctl(16'h0000);
        fire(2);
        no_msg("R6 disabled silent", 8);
        rd(1, 1, 7'h00, r);  chk("R6 pba bits 2 and 6", r, 64'h44);
        rd(0, 1, 7'h04, r);  chk("R6 pba upper half", r, 64'h0);

        // R11 enable alone does not replay
        ctl(16'h8000);
        no_msg("R11 enable silent", 8);
        rd(1, 1, 7'h00, r);  chk("R11 pba kept", r, 64'h44);

        // R7 vector unmask replays only that vector
        wr(0, 0, 7'h6C, 64'h0);
        expect_msg("R7 vec6", 6, w);
        @(negedge clk);
        rd(1, 1, 7'h00, r);  chk("R7 pba only vec2", r, 64'h04);

        // R8 function unmask replays in order
        ctl(16'hC000);
        wr(0, 0, 7'h7C, 64'h1);
        fire(4); fire(1); fire(7);
        rd(1, 1, 7'h00, r);  chk("R8 pba before", r, 64'h96);
        wr(1, 1, 7'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(1, 1, 7'h00, r);  chk("R3 pba write ignored", r, 64'h96);
        ctl(16'h8000);
        expect_msg("R8 first vec1", 1, w);
        expect_msg("R8 second vec2", 2, w);
        chk("R8 back-to-back 2", 64'(w), 64'd1);
        expect_msg("R8 third vec4", 4, w);
        chk("R8 back-to-back 4", 64'(w), 64'd1);
        @(negedge clk);
        chk("R8 idle after", 64'(msg_valid), 64'd0);
        rd(1, 1, 7'h00, r);  chk("R8 masked vec7 still pending", r, 64'h80);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule